// File: doc/BRIEF.md
# Device Reset Sequencer

This block turns reset requests into one ordered device reset. The requests come from an active-low external reset pin, a software reset pulse, a watchdog expiry and a debug-originated reset. A small per-source configuration word decides whether the pin, software and watchdog requests run a hard sequence or a soft sequence. A debug request always runs a hard one. The power-on reset input clears the block asynchronously, and every power-up is followed by a hard sequence.

Each sequence has three phases. First comes an initialization phase, during which the active-low status output is held low and the domain reset enables are asserted. Next the block requests a fixed pause of the system clock. Finally it issues a one-cycle boot-start strobe. A hard sequence resets both the ordinary register domain and the retained (sticky) domain, and it re-latches the boot-configuration pins. A soft sequence resets only the ordinary domain and keeps the previously latched boot word. Requests that arrive while a sequence is in progress are dropped.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While idle, any asserted request (`pin_rst_n` low, `sw_rst_req`, `wdog_expire` or `dbg_rst_req` high) sampled at a rising edge starts a sequence. `rst_stat_n` is low from the following cycle.
- R2: After power-on reset, `soft_cfg` reads 3'b000, which means every source is hard.
- R3: `soft_cfg` is written from `cfg_wdata` when `cfg_we` is high. Bit 0 selects the pin, bit 1 software and bit 2 the watchdog, and a 1 makes that source soft. A debug request is always hard.
- R4: When several requests are sampled together, the sequence is hard if any one of them maps to hard.
- R5: `rst_plain` is high on every cycle that `rst_stat_n` is low. `rst_retained` is high on those same cycles for a hard sequence and never high for a soft one.
- R6: The initialization phase lasts exactly INIT_CYCLES cycles (default 64), with `rst_stat_n` low throughout.
- R7: `clk_pause` is high for exactly PAUSE_CYCLES cycles (default 8), starting in the cycle in which `rst_stat_n` returns high.
- R8: `boot_start` is a single-cycle pulse in the cycle right after the last pause cycle.
- R9: A hard sequence loads `boot_pins` into `boot_cfg` by the end of initialization. A soft sequence leaves `boot_cfg` unchanged.
- R10: Requests sampled during initialization, pause or the boot-start cycle are ignored and do not change the running sequence, its type, or what follows it.
- R11: Low `por_n` immediately drives `rst_stat_n` low, `rst_plain` and `rst_retained` high, and clears `soft_cfg` and `boot_cfg`, even in the middle of a soft sequence. Its release runs a full hard sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_rst_n | input | 1 | External reset request, active low |
| sw_rst_req | input | 1 | Software reset request |
| wdog_expire | input | 1 | Watchdog expiry request |
| dbg_rst_req | input | 1 | Debug reset request, always hard |
| cfg_we | input | 1 | Write strobe for the soft-select word |
| cfg_wdata | input | 3 | Soft-select bits {wdog, sw, pin} |
| boot_pins | input | CFG_W | Boot-configuration pin values |
| soft_cfg | output | 3 | Current soft-select word |
| rst_stat_n | output | 1 | Reset status, low while initializing |
| rst_plain | output | 1 | Reset enable for the non-retained domain |
| rst_retained | output | 1 | Reset enable for the retained domain |
| clk_pause | output | 1 | System clock pause request |
| boot_start | output | 1 | One-cycle boot start strobe |
| boot_cfg | output | CFG_W | Latched boot-configuration word |

## Verification
Each source is first fired alone under the all-hard default and then alone with its own soft bit set. This separates a correct per-bit decode from a swapped or ignored bit. Mixed requests pair a soft source with a hard one to show that hard wins, and all three configurable sources are also fired together while set soft. A debug request is fired with every soft bit set, which shows it cannot be made soft. Each pattern is measured for phase lengths, phase order, domain masks and the boot word. Further runs inject requests in the middle of a sequence and in the boot cycle, and assert power-on reset inside a soft sequence.

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int INIT_CYCLES  = 64,
  parameter int PAUSE_CYCLES = 8,
  parameter int CFG_W        = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             pin_rst_n,
  input  logic             sw_rst_req,
  input  logic             wdog_expire,
  input  logic             dbg_rst_req,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_wdata,
  input  logic [CFG_W-1:0] boot_pins,
  output logic [2:0]       soft_cfg,
  output logic             rst_stat_n,
  output logic             rst_plain,
  output logic             rst_retained,
  output logic             clk_pause,
  output logic             boot_start,
  output logic [CFG_W-1:0] boot_cfg
);

  localparam int MAXC  = (INIT_CYCLES > PAUSE_CYCLES) ? INIT_CYCLES : PAUSE_CYCLES;
  localparam int CNT_W = $clog2(MAXC) + 1;

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_PAUSE, S_BOOT} st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic             hard_q;
  logic [2:0]       soft_q;
  logic [CFG_W-1:0] boot_q;

  wire pin_req  = ~pin_rst_n;
  wire any_req  = pin_req | sw_rst_req | wdog_expire | dbg_rst_req;
  wire hard_sel = dbg_rst_req | (pin_req & ~soft_q[0])
                | (sw_rst_req & ~soft_q[1]) | (wdog_expire & ~soft_q[2]);
  wire init_end  = (cnt == CNT_W'(INIT_CYCLES - 1));
  wire pause_end = (cnt == CNT_W'(PAUSE_CYCLES - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state  <= S_INIT;
      cnt    <= '0;
      hard_q <= 1'b1;
      soft_q <= '0;
      boot_q <= '0;
    end else begin
      if (cfg_we) soft_q <= cfg_wdata;
      if (state == S_INIT && hard_q) boot_q <= boot_pins;
      case (state)
        S_IDLE: if (any_req) begin
          state  <= S_INIT;
          cnt    <= '0;
          hard_q <= hard_sel;
        end
        S_INIT: if (init_end) begin
          state <= S_PAUSE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        S_PAUSE: if (pause_end) begin
          state <= S_BOOT;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign soft_cfg     = soft_q;
  assign boot_cfg     = boot_q;
  assign rst_stat_n   = (state != S_INIT);
  assign rst_plain    = (state == S_INIT);
  assign rst_retained = (state == S_INIT) && hard_q;
  assign clk_pause    = (state == S_PAUSE);
  assign boot_start   = (state == S_BOOT);

  // R5: the retained domain is never reset without the plain domain
  p_retained_in_plain_r5: assert property (@(posedge clk) disable iff (!por_n)
    rst_retained |-> rst_plain);

  // R7: status release coincides with the start of the clock pause
  p_pause_on_release_r7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_stat_n) |-> clk_pause);

  // R8: boot strobe follows the pause and lasts one cycle
  p_boot_after_pause_r8: assert property (@(posedge clk) disable iff (!por_n)
    $fell(clk_pause) |-> boot_start);
  p_boot_single_r8: assert property (@(posedge clk) disable iff (!por_n)
    boot_start |=> !boot_start);

  // R3: a debug request taken from idle always resets the retained domain
  p_dbg_hard_r3: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_IDLE && dbg_rst_req) |=> rst_retained);

  // R9: a soft sequence keeps the boot word
  p_soft_keeps_boot_r9: assert property (@(posedge clk) disable iff (!por_n)
    (rst_plain && !rst_retained) |=> $stable(boot_cfg));

  // R10: no new sequence starts from the pause phase
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!por_n)
    clk_pause |=> rst_stat_n);

endmodule

// File: tb/test_rst_seq_ctrl.sv
module test_rst_seq_ctrl;
  localparam int CFG_W = 16;
  localparam int INIT  = 64;
  localparam int PAUSE = 8;
  localparam int WIN   = 90;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por_n = 1'b0, pin_rst_n = 1'b1, sw_rst_req = 1'b0, wdog_expire = 1'b0, dbg_rst_req = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic [CFG_W-1:0] boot_pins = 16'hA5C3;
  logic [2:0] soft_cfg;
  logic rst_stat_n, rst_plain, rst_retained, clk_pause, boot_start;
  logic [CFG_W-1:0] boot_cfg;

  rst_seq_ctrl #(.INIT_CYCLES(INIT), .PAUSE_CYCLES(PAUSE), .CFG_W(CFG_W)) i_rst_seq_ctrl (
    .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .sw_rst_req(sw_rst_req),
    .wdog_expire(wdog_expire), .dbg_rst_req(dbg_rst_req), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .boot_pins(boot_pins), .soft_cfg(soft_cfg),
    .rst_stat_n(rst_stat_n), .rst_plain(rst_plain), .rst_retained(rst_retained),
    .clk_pause(clk_pause), .boot_start(boot_start), .boot_cfg(boot_cfg));

  int n_chk = 0, n_fail = 0;
  logic [CFG_W-1:0] exp_boot;

  // {pin, sw, wdog, dbg, cfg[2:0], exp_hard, pins[15:0]}
  localparam int NV = 10;
  localparam logic [23:0] VEC [NV] = '{
    {4'b1000, 3'b000, 1'b1, 16'h1111},
    {4'b0100, 3'b000, 1'b1, 16'h2222},
    {4'b0010, 3'b000, 1'b1, 16'h3333},
    {4'b1000, 3'b001, 1'b0, 16'h4444},
    {4'b0100, 3'b010, 1'b0, 16'h5555},
    {4'b0010, 3'b100, 1'b0, 16'h6666},
    {4'b0001, 3'b111, 1'b1, 16'h7777},
    {4'b1100, 3'b001, 1'b1, 16'h8888},
    {4'b1110, 3'b111, 1'b0, 16'h9999},
    {4'b0100, 3'b101, 1'b1, 16'hAAAA}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] r);
    pin_rst_n = ~r[3]; sw_rst_req = r[2]; wdog_expire = r[1]; dbg_rst_req = r[0];
  endtask

  // Samples WIN negedges starting at the current one; optional injections.
  task automatic measure(input bit inject, input bit hard, input string tag);
    int ni = 0, np = 0, nb = 0, nr = 0, npl = 0, firstp = -1, lastp = -1, bidx = -1, firstlow = -1;
    for (int i = 0; i < WIN; i++) begin
      if (!rst_stat_n) begin ni++; if (firstlow < 0) firstlow = i; end
      if (rst_plain) npl++;
      if (rst_retained) nr++;
      if (clk_pause) begin np++; if (firstp < 0) firstp = i; lastp = i; end
      if (boot_start) begin nb++; bidx = i; end
      if (inject) drive((i == 10) ? 4'b0010 : (i == INIT + PAUSE) ? 4'b0001 : 4'b0000);
      @(negedge clk);
    end
    drive(4'b0000);
    chk(firstlow == 0, "R1", {tag, " status low at once"}, firstlow, 0);
    chk(ni == INIT, "R6", {tag, " init length"}, ni, INIT);
    chk(npl == INIT, "R5", {tag, " plain domain cycles"}, npl, INIT);
    chk(nr == (hard ? INIT : 0), "R5", {tag, " retained domain cycles"}, nr, hard ? INIT : 0);
    chk(np == PAUSE && firstp == INIT, "R7", {tag, " pause length/start"}, np * 256 + firstp, PAUSE * 256 + INIT);
    chk(nb == 1 && bidx == lastp + 1, "R8", {tag, " boot strobe"}, nb * 256 + bidx, 256 + INIT + PAUSE);
    chk(boot_cfg == exp_boot, "R9", {tag, " boot word"}, boot_cfg, exp_boot);
  endtask

  task automatic write_cfg(input logic [2:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic fire(input logic [3:0] r);
    @(negedge clk); drive(r);
    @(negedge clk); drive(4'b0000);
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R11 / R2: state under power-on reset
    #10;
    chk(rst_stat_n == 1'b0, "R11", "status under POR", rst_stat_n, 0);
    chk(rst_plain && rst_retained, "R11", "domains under POR", {rst_plain, rst_retained}, 3);
    chk(soft_cfg == 3'b000, "R2", "default soft select", soft_cfg, 0);
    exp_boot = boot_pins;
    @(negedge clk); por_n = 1'b1;
    measure(1'b0, 1'b1, "power-up");

    // R1 R3 R4 R9: vector table
    for (int v = 0; v < NV; v++) begin
      write_cfg(VEC[v][19:17]);
      chk(soft_cfg == VEC[v][19:17], "R3", "soft select readback", soft_cfg, VEC[v][19:17]);
      boot_pins = VEC[v][15:0];
      if (VEC[v][16]) exp_boot = VEC[v][15:0];
      fire(VEC[v][23:20]);
      measure(1'b0, VEC[v][16], $sformatf("vec%0d", v));
    end

    // R10: requests during the sequence and in the boot cycle are ignored
    write_cfg(3'b010);
    boot_pins = 16'hBEEF;
    fire(4'b0100);
    measure(1'b1, 1'b0, "R10 inject");
    repeat (5) @(negedge clk);
    chk(rst_stat_n == 1'b1, "R10", "idle after ignored requests", rst_stat_n, 1);

    // R11: POR inside a soft sequence
    write_cfg(3'b001);
    fire(4'b1000);
    repeat (10) @(negedge clk);
    chk(rst_retained == 1'b0, "R5", "soft sequence spares retained", rst_retained, 0);
    por_n = 1'b0; boot_pins = 16'h0F0F;
    #1;
    chk(rst_retained == 1'b1 && rst_stat_n == 1'b0, "R11", "POR forces hard", {rst_retained, rst_stat_n}, 2);
    chk(soft_cfg == 3'b000 && boot_cfg == '0, "R11", "POR clears config", {soft_cfg, boot_cfg}, 0);
    @(negedge clk); por_n = 1'b1;
    exp_boot = 16'h0F0F;
    measure(1'b0, 1'b1, "R11 after POR");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule